// File: doc/BRIEF.md
# Transceiver SPI Access Engine

This block is an SPI master, fixed to mode 0 with 8-bit frames, that runs one register, FIFO or command access to a radio transceiver for each host request. A request carries an address byte, a read flag and a byte count. The engine forms the header byte from these. It sends the header and keeps the byte that the transceiver returns during the header as the chip status. It then streams data bytes out from `wr_data` or in to `rd_data`. A count of zero makes the access a command strobe, which sends the header byte alone.

Chip select stays low from before the first SCLK edge until at least half an SCLK period after the last one. Two parameters set the SCLK half period in core clock cycles, one for single-byte accesses and one for bursts, so a burst can run at a lower SCLK rate. One request is invalid: an address byte that already has its read bit set combined with a count other than one. The engine rejects it with an error pulse and does not touch the bus.

The controller uses five states. `ST_IDLE` waits for a request. It goes to `ST_SHIFT` on a valid request and to `ST_REJ` on an invalid one. `ST_SHIFT` runs the byte shifter once per byte, header first. When the last byte is done it goes to `ST_HOLD`, which keeps chip select low for one half period. `ST_FIN` raises chip select and pulses done. `ST_REJ` pulses err. Both `ST_FIN` and `ST_REJ` return to `ST_IDLE`.

Top module: `xcvr_spi_engine`

## Requirements
- R1: Header bit 7 is set when `req_read` is high or `req_addr[7]` is high. Header bit 6 is set when `req_len` > 1 or `req_addr[6]` is high. Header bits 5:0 equal `req_addr[5:0]`. Every byte is sent MSB first.
- R2: When `req_len` = 0 the access is a command strobe: exactly one byte (the header) is clocked, and no data is streamed.
- R3: The byte sampled on `miso` during the header is held as status until the next access. `st_rdy_n` is its bit 7, `st_state` is bits 6:4 and `st_fifo` is bits 3:0.
- R4: A write (header bit 7 clear) sends `req_len` data bytes after the header, taken in order from `wr_data`. `wr_take` pulses for one cycle after each byte is loaded, and the next byte must then be presented.
- R5: A read (header bit 7 set) clocks `req_len` bytes after the header with `mosi` low. Each received byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in order.
- R6: A request with `req_addr[7]` high and `req_len` other than 1 gives a one-cycle `err` pulse. `cs_n` stays high, no SCLK edge occurs and `done` does not pulse.
- R7: Mode 0 timing: `sclk` is low whenever `cs_n` is high, `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge.
- R8: Each SCLK high phase lasts DIV_BURST core cycles when `req_len` > 1, and DIV_SINGLE cycles otherwise.
- R9: `cs_n` falls once per access, at least one half period before the first rising SCLK edge. It rises at least one half period after the last falling edge, and `done` pulses for one cycle in the cycle `cs_n` returns high.
- R10: After reset `cs_n` is high, and `sclk`, `done`, `err` and `busy` are low.
- R11: `busy` is high from acceptance until `done` or `err`. A `req_valid` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (sampled when idle) |
| req_addr | input | 8 | Address byte; bits 7:6 may pre-set read/burst |
| req_read | input | 1 | Request is a read |
| req_len | input | LEN_W | Data byte count; 0 = command strobe |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | Pulse: current `wr_data` consumed |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | Pulse: `rd_data` valid |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to transceiver |
| miso | input | 1 | Serial data from transceiver |
| busy | output | 1 | Access in progress |
| done | output | 1 | Pulse: access complete |
| err | output | 1 | Pulse: request rejected |
| st_rdy_n | output | 1 | Status: chip not ready |
| st_state | output | 3 | Status: transceiver state |
| st_fifo | output | 4 | Status: FIFO byte count |

## Verification
The bench targets the header encoding for each combination of direction, length and pre-set address bits. Examples are a status-register read whose address already carries both top bits, and a read strobe with a zero count. A wrong encoding appears as a bad first byte at the slave model. It also rejects read-bit requests with bad lengths; a design that let one through would drop chip select and clock bytes. Half-period lengths are measured on every clock for single and burst accesses. A design that picks the divider from the wrong length, or that releases chip select right after the last edge, breaks the measured run lengths. A request injected in the middle of a burst checks that a busy engine ignores new requests rather than restarting.

// File: rtl/xspi_pkg.sv
package xspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_FIN,
        ST_REJ
    } xspi_state_e;

    typedef struct packed {
        logic       rdy_n;
        logic [2:0] state;
        logic [3:0] fifo;
    } xspi_status_t;

endpackage

// File: rtl/xspi_hdr.sv
module xspi_hdr #(
    parameter int LEN_W = 7
) (
    input  logic [7:0]       addr,
    input  logic             rd,
    input  logic [LEN_W-1:0] len,
    output logic [7:0]       hdr,
    output logic             is_read,
    output logic             multi,
    output logic             bad
);
    always_comb begin
        multi   = (len > LEN_W'(1));
        is_read = rd | addr[7];
        hdr     = {is_read, addr[6] | multi, addr[5:0]};
        bad     = addr[7] && (len != LEN_W'(1));
    end
endmodule

// File: rtl/xspi_shift.sv
module xspi_shift #(
    parameter int HALF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        tx,
    input  logic [HALF_W-1:0] half,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_done,
    output logic [7:0]        rx
);
    logic              active;
    logic              sclk_q;
    logic [HALF_W-1:0] cnt;
    logic [2:0]        bits;
    logic [7:0]        tx_sh;
    logic [7:0]        rx_sh;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk_q <= 1'b0;
            cnt    <= '0;
            bits   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active <= 1'b1;
                sclk_q <= 1'b0;
                cnt    <= '0;
                bits   <= '0;
                tx_sh  <= tx;
            end else if (active) begin
                if (cnt == half - HALF_W'(1)) begin
                    cnt    <= '0;
                    sclk_q <= ~sclk_q;
                    if (!sclk_q) begin
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        bits  <= bits + 3'd1;
                        if (bits == 3'd7) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    cnt <= cnt + HALF_W'(1);
                end
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = tx_sh[7];
    assign rx        = rx_sh;
    assign byte_done = done_q;

    // R7: data out only moves while the clock is low
    assert_mosi_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi));

    // R9: a byte never finishes with the clock left high
    assert_done_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !sclk_q);
endmodule

// File: rtl/xcvr_spi_engine.sv
module xcvr_spi_engine
    import xspi_pkg::*;
#(
    parameter int LEN_W      = 7,
    parameter int DIV_SINGLE = 2,
    parameter int DIV_BURST  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_addr,
    input  logic             req_read,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             st_rdy_n,
    output logic [2:0]       st_state,
    output logic [3:0]       st_fifo
);
    localparam int DIV_MAX = (DIV_BURST > DIV_SINGLE) ? DIV_BURST : DIV_SINGLE;
    localparam int HALF_W  = $clog2(DIV_MAX + 1);

    xspi_state_e       state, state_nx;
    logic [LEN_W-1:0]  remain;
    logic              rd_mode;
    logic              hdr_phase;
    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] hcnt;
    xspi_status_t      status_q;
    logic [7:0]        rd_q;
    logic              rd_v_q;
    logic              take_q;

    logic [7:0] hdr;
    logic       h_read, h_multi, h_bad;
    logic       start;
    logic [7:0] tx_byte;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic       accept;
    logic       more;

    xspi_hdr #(.LEN_W(LEN_W)) u_hdr (
        .addr    (req_addr),
        .rd      (req_read),
        .len     (req_len),
        .hdr     (hdr),
        .is_read (h_read),
        .multi   (h_multi),
        .bad     (h_bad)
    );

    xspi_shift #(.HALF_W(HALF_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx        (tx_byte),
        .half      (half_q),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx        (rx_byte)
    );

    assign accept = (state == ST_IDLE) && req_valid && !h_bad;
    assign more   = (remain != '0);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = h_bad ? ST_REJ : ST_SHIFT;
            ST_SHIFT: if (byte_done && !more) state_nx = ST_HOLD;
            ST_HOLD:  if (hcnt == half_q - HALF_W'(1)) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            ST_REJ:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain    <= '0;
            rd_mode   <= 1'b0;
            hdr_phase <= 1'b0;
            half_q    <= HALF_W'(DIV_SINGLE);
            hcnt      <= '0;
            status_q  <= '0;
            rd_q      <= '0;
            rd_v_q    <= 1'b0;
            take_q    <= 1'b0;
        end else begin
            rd_v_q <= 1'b0;
            take_q <= 1'b0;
            hcnt   <= (state == ST_HOLD) ? hcnt + HALF_W'(1) : '0;
            if (accept) begin
                remain    <= req_len;
                rd_mode   <= h_read;
                hdr_phase <= 1'b1;
                half_q    <= h_multi ? HALF_W'(DIV_BURST) : HALF_W'(DIV_SINGLE);
            end else if (state == ST_SHIFT && byte_done) begin
                if (hdr_phase) begin
                    status_q  <= xspi_status_t'(rx_byte);
                    hdr_phase <= 1'b0;
                end else if (rd_mode) begin
                    rd_q   <= rx_byte;
                    rd_v_q <= 1'b1;
                end
                if (more) begin
                    remain <= remain - LEN_W'(1);
                    take_q <= !rd_mode;
                end
            end
        end
    end

    // outputs
    always_comb begin
        start   = accept || (state == ST_SHIFT && byte_done && more);
        tx_byte = (state == ST_IDLE) ? hdr : (rd_mode ? 8'h00 : wr_data);
        cs_n    = !(state == ST_SHIFT || state == ST_HOLD);
        done    = (state == ST_FIN);
        err     = (state == ST_REJ);
        busy    = (state != ST_IDLE);
    end

    assign wr_take  = take_q;
    assign rd_data  = rd_q;
    assign rd_valid = rd_v_q;
    assign st_rdy_n = status_q.rdy_n;
    assign st_state = status_q.state;
    assign st_fifo  = status_q.fifo;

    // R7: clock idles low outside an access
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R9: done marks the release of chip select and lasts one cycle
    assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a rejected request never selects the device
    assert_err_nocs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && $past(cs_n)));

    // R5: read data only arrives during a selected access
    assert_rd_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    // R11: busy covers every cycle of selection
    assert_busy_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
endmodule

// File: tb/xcvr_spi_engine_test.sv
`timescale 1ns/1ps
module xcvr_spi_engine_test;
    localparam int LW = 7;
    localparam int HS = 2;
    localparam int HB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic req_read = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic [7:0] wr_data;
    logic wr_take, rd_valid, sclk, cs_n, mosi, busy, done, err, st_rdy_n;
    logic [7:0] rd_data;
    logic [2:0] st_state;
    logic [3:0] st_fifo;
    logic miso_r = 1'b0;

    always #2.5 clk = ~clk;

    xcvr_spi_engine #(.LEN_W(LW), .DIV_SINGLE(HS), .DIV_BURST(HB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso_r), .busy(busy), .done(done), .err(err), .st_rdy_n(st_rdy_n),
        .st_state(st_state), .st_fifo(st_fifo)
    );

    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // slave model
    logic [7:0] resp [0:15];
    logic [7:0] wbuf [0:15];
    logic [7:0] got [$];
    logic [7:0] rdq [$];
    int sbit, sbyte, widx;
    logic [7:0] cur, acc;

    assign wr_data = wbuf[widx & 15];

    always @(negedge cs_n) begin
        sbit = 0; sbyte = 0; cur = resp[0]; miso_r = cur[7];
    end
    always @(posedge sclk) if (!cs_n) begin
        acc = {acc[6:0], mosi};
        sbit++;
        if (sbit == 8) begin got.push_back(acc); sbit = 0; end
    end
    always @(negedge sclk) if (!cs_n) begin
        if (sbit == 0) begin sbyte++; cur = resp[sbyte & 15]; end
        else cur = {cur[6:0], 1'b0};
        miso_r = cur[7];
    end

    // per-clock timing model
    int exp_half = HS;
    int run = 0, lead = 0, tail = 0, cs_falls = 0, done_cnt = 0, err_cnt = 0;
    bit prev_s = 0, prev_cs = 1, prev_mosi = 0, first_pending = 0;

    always @(negedge clk) if (rst_n) begin
        if (cs_n && sclk) begin fails++; $display("FAIL R7 sclk=%0d expected=0 with cs_n high", sclk); end
        if (sclk && prev_s && mosi != prev_mosi) begin
            fails++; $display("FAIL R7 mosi=%0d expected=%0d while sclk high", mosi, prev_mosi);
        end
        if (!cs_n && prev_cs) begin cs_falls++; first_pending = 1; lead = 0; end
        if (!cs_n && !sclk && first_pending) lead++;
        if (sclk != prev_s) begin
            if (prev_s) begin
                chk(run == exp_half, "R8 high phase", run, exp_half);
                tail = 0;
            end else if (first_pending) begin
                chk(lead >= exp_half, "R9 cs lead", lead, exp_half);
                first_pending = 0;
            end
            run = 1;
        end else run++;
        if (!cs_n && !sclk) tail++;
        if (cs_n && !prev_cs) chk(tail >= exp_half, "R9 cs tail", tail, exp_half);
        if (done) begin
            done_cnt++;
            chk(cs_n && !prev_cs, "R9 done at cs release", {prev_cs, cs_n}, 1);
        end
        if (err) err_cnt++;
        if (rd_valid) rdq.push_back(rd_data);
        if (wr_take) widx++;
        prev_s = sclk; prev_cs = cs_n; prev_mosi = mosi;
    end

    task automatic launch(input logic [7:0] a, input logic r, input int n, input int hx, input bit inject);
        got.delete(); rdq.delete();
        widx = 0; cs_falls = 0; done_cnt = 0; err_cnt = 0; exp_half = hx;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_read = r; req_len = LW'(n);
        @(negedge clk);
        req_valid = 0;
        chk(busy || err, "R11 busy after accept", busy, 1);
        if (inject) begin
            repeat (3) @(negedge clk);
            req_valid = 1; req_addr = 8'h11; req_read = 0; req_len = LW'(1);
            @(negedge clk);
            req_valid = 0;
        end
        for (int i = 0; i < 3000; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_ok(input logic [7:0] a, input logic r, input int n,
                          input logic [7:0] hexp, input int hx, input bit inject);
        launch(a, r, n, hx, inject);
        chk(done_cnt == 1, "R9 one done", done_cnt, 1);
        chk(cs_falls == 1, "R9 one cs fall", cs_falls, 1);
        chk(err_cnt == 0, "R6 no err", err_cnt, 0);
        chk(busy == 0, "R11 idle after done", busy, 0);
        chk(got.size() == n + 1, "R2 byte count", got.size(), n + 1);
        if (got.size() > 0) chk(got[0] == hexp, "R1 header", got[0], hexp);
        chk({st_rdy_n, st_state, st_fifo} == resp[0], "R3 status", {st_rdy_n, st_state, st_fifo}, resp[0]);
        if (!hexp[7]) begin
            chk(widx == n, "R4 take count", widx, n);
            for (int i = 1; i < got.size(); i++)
                chk(got[i] == wbuf[i-1], "R4 write byte", got[i], wbuf[i-1]);
        end else begin
            chk(rdq.size() == n, "R5 read count", rdq.size(), n);
            for (int i = 0; i < rdq.size(); i++)
                chk(rdq[i] == resp[i+1], "R5 read byte", rdq[i], resp[i+1]);
            for (int i = 1; i < got.size(); i++)
                chk(got[i] == 8'h00, "R5 mosi low", got[i], 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin resp[i] = 8'h00; wbuf[i] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(cs_n == 1, "R10 cs_n", cs_n, 1);
        chk(sclk == 0, "R10 sclk", sclk, 0);
        chk({done, err, busy} == 3'b000, "R10 flags", {done, err, busy}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // single write
        resp[0] = 8'h9B; wbuf[0] = 8'h5C;
        run_ok(8'h0A, 0, 1, 8'h0A, HS, 0);
        // burst write to FIFO address
        resp[0] = 8'h13; wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        run_ok(8'h3F, 0, 3, 8'h7F, HB, 0);
        // single read
        resp[0] = 8'h0F; resp[1] = 8'h3C;
        run_ok(8'h06, 1, 1, 8'h86, HS, 0);
        // burst read
        resp[0] = 8'hE4; resp[1] = 8'h81; resp[2] = 8'h7E; resp[3] = 8'h55; resp[4] = 8'h02;
        run_ok(8'h3F, 1, 4, 8'hFF, HB, 0);
        // status register read with both top bits pre-set
        resp[0] = 8'h21; resp[1] = 8'h04;
        run_ok(8'hF1, 0, 1, 8'hF1, HS, 0);
        // command strobe, then strobe with read bit
        resp[0] = 8'h2F;
        run_ok(8'h36, 0, 0, 8'h36, HS, 0);
        resp[0] = 8'h15;
        run_ok(8'h3D, 1, 0, 8'hBD, HS, 0);
        // rejected requests
        launch(8'hB0, 0, 2, HS, 0);
        chk(err_cnt == 1, "R6 err pulse", err_cnt, 1);
        chk(cs_falls == 0, "R6 no select", cs_falls, 0);
        chk(got.size() == 0, "R6 no bytes", got.size(), 0);
        chk(done_cnt == 0, "R6 no done", done_cnt, 0);
        launch(8'h80, 0, 0, HS, 0);
        chk(err_cnt == 1, "R6 err on zero length", err_cnt, 1);
        chk(cs_falls == 0, "R6 no select zero length", cs_falls, 0);
        // request injected mid-burst is ignored
        resp[0] = 8'h40; wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        run_ok(8'h3F, 0, 4, 8'h7F, HB, 1);
        repeat (20) @(negedge clk);
        chk(cs_falls == 1, "R11 no restart", cs_falls, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule